// File: doc/BRIEF.md
# Sliding-Window Two-of-Four Detector

This block watches a serial bit stream and raises its flag in every cycle where exactly two of the four newest bits are 1. The four bits are the bit on the input in the present cycle and the three accepted before it. It is a Mealy machine. A short history register keeps only the past bits. Combinational logic forms the decision from the number of ones in that history and from the bit on the input now.

The stream advances only in cycles where the input is marked valid. A build-time switch selects the output form. In one form the flag follows the decision in the same cycle. In the other form the decision passes through a flip-flop on the same clock, which removes gate-level glitches and delays the flag by one cycle. The window length is a parameter with a default of four. The target count stays at two.

Top module: `twoOfFourDetect`

## Requirements
- R1: A synchronous active-high reset clears the history register, and the output register when present, to 0. The windows that follow reset treat the bits before reset as 0: after reset, valid inputs 1 then 1 give the decisions 0 then 1.
- R2: With the input valid, the decision is 1 exactly when the present bit and the three previous valid bits together contain two ones.
- R3: With a valid present bit of 0, the decision is 1 only when the history holds exactly two ones.
- R4: With a valid present bit of 1, the decision is 1 only when the history holds exactly one one.
- R5: On each clock edge with valid high, the history shifts left by one place. The present bit enters at bit 0 and the oldest bit (bit 2) is discarded. For example, history 101 with input 1 becomes 011.
- R6: With valid low, the history is held and the decision is 0.
- R7: With REG_OUT=1, detOut equals the decision of the previous cycle. With REG_OUT=0, detOut is the decision of the present cycle.
- R8: The following fixed cases hold. History 000 with input 1 gives 0. History 001 with input 1 gives 1. History 110 with input 0 gives 1. History 111 with either input gives 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Marks inBit as a stream bit for this cycle |
| inBit | input | 1 | Serial data bit |
| detOut | output | 1 | Two-of-four flag (combinational or registered) |

## Verification
A wrong history bit shows at the ports only when a later window makes the count cross two. A shift error or a corrupted bit can therefore stay hidden until a pattern such as a single one followed by a one arrives. For this reason the sweep loads each of the eight histories explicitly and then tries both input values. That exposes any bad history within four valid cycles. A history that moves while valid is low is caught by the first valid bit after the gap. In registered mode every error appears exactly one cycle after the cycle that caused it.

// File: rtl/twoOfFourPkg.sv
package twoOfFourPkg;
  // number of ones in the window that raises the flag
  localparam int unsigned HIT_COUNT = 2;

  typedef struct packed {
    logic shiftEn;  // accept present bit into history
    logic hit;      // decision for this cycle
  } detStrobes_t;
endpackage

// File: rtl/detHistPath.sv
module detHistPath
  import twoOfFourPkg::*;
#(
  parameter int unsigned WIN     = 4,
  parameter bit          REG_OUT = 1'b0
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       inBit,
  input  detStrobes_t                strobes,
  output logic [WIN-2:0]             histQ,
  output logic [$clog2(WIN+1)-1:0]   histOnes,
  output logic                       detOut
);
  localparam int unsigned HIST_W = WIN - 1;
  localparam int unsigned CNT_W  = $clog2(WIN + 1);

  // history shift register, newest bit at position 0
  always_ff @(posedge clk) begin
    if (rst)                  histQ <= '0;
    else if (strobes.shiftEn) histQ <= {histQ[HIST_W-2:0], inBit};
  end

  // popcount of the history
  always_comb begin
    histOnes = '0;
    for (int i = 0; i < HIST_W; i++) histOnes = histOnes + CNT_W'(histQ[i]);
  end

  generate
    if (REG_OUT) begin : gRegOut
      logic flagQ;
      always_ff @(posedge clk) begin
        if (rst) flagQ <= 1'b0;
        else     flagQ <= strobes.hit;
      end
      assign detOut = flagQ;
    end else begin : gCombOut
      assign detOut = strobes.hit;
    end
  endgenerate
endmodule

// File: rtl/detDecide.sv
module detDecide
  import twoOfFourPkg::*;
#(
  parameter int unsigned WIN = 4
) (
  input  logic                      inValid,
  input  logic                      inBit,
  input  logic [$clog2(WIN+1)-1:0]  histOnes,
  output detStrobes_t               strobes
);
  localparam int unsigned CNT_W = $clog2(WIN + 1);
  localparam logic [CNT_W-1:0] NEED_IF_ZERO = CNT_W'(HIT_COUNT);
  localparam logic [CNT_W-1:0] NEED_IF_ONE  = CNT_W'(HIT_COUNT - 1);

  logic matchZero;
  logic matchOne;

  assign matchZero = (histOnes == NEED_IF_ZERO);
  assign matchOne  = (histOnes == NEED_IF_ONE);

  always_comb begin
    strobes.shiftEn = inValid;
    strobes.hit     = inValid && (inBit ? matchOne : matchZero);
  end
endmodule

// File: rtl/twoOfFourDetect.sv
module twoOfFourDetect
  import twoOfFourPkg::*;
#(
  parameter int unsigned WIN     = 4,
  parameter bit          REG_OUT = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic inValid,
  input  logic inBit,
  output logic detOut
);
  localparam int unsigned CNT_W = $clog2(WIN + 1);

  detStrobes_t          strobes;
  logic [WIN-2:0]       histQ;
  logic [CNT_W-1:0]     histOnes;
  logic                 hitNow;

  detDecide #(.WIN(WIN)) uDecide (
    .inValid (inValid),
    .inBit   (inBit),
    .histOnes(histOnes),
    .strobes (strobes)
  );

  detHistPath #(.WIN(WIN), .REG_OUT(REG_OUT)) uPath (
    .clk     (clk),
    .rst     (rst),
    .inBit   (inBit),
    .strobes (strobes),
    .histQ   (histQ),
    .histOnes(histOnes),
    .detOut  (detOut)
  );

  assign hitNow = strobes.hit;
endmodule

// File: rtl/twoOfFourChk.sv
module twoOfFourChk #(
  parameter int unsigned WIN     = 4,
  parameter bit          REG_OUT = 1'b0
) (
  input logic           clk,
  input logic           rst,
  input logic           inValid,
  input logic           inBit,
  input logic           detOut,
  input logic [WIN-2:0] histQ,
  input logic           hit
);
  // R1
  rst_clears_hist_chk: assert property (@(posedge clk) rst |=> (histQ == '0));

  // R5
  hist_shift_chk: assert property (@(posedge clk) disable iff (rst)
    inValid |=> (histQ == {$past(histQ[WIN-3:0]), $past(inBit)}));

  // R6
  hist_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> $stable(histQ));

  // R6
  idle_no_hit_chk: assert property (@(posedge clk) disable iff (rst)
    !inValid |-> !hit);

  // R3
  zero_bit_hit_chk: assert property (@(posedge clk) disable iff (rst)
    (inValid && !inBit) |-> (hit == ($countones(histQ) == 2)));

  // R4
  one_bit_hit_chk: assert property (@(posedge clk) disable iff (rst)
    (inValid && inBit) |-> (hit == ($countones(histQ) == 1)));

  generate
    if (REG_OUT) begin : gRegChk
      // R7
      reg_delay_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (detOut == $past(hit)));
    end else begin : gCombChk
      // R7
      comb_idle_out_chk: assert property (@(posedge clk) disable iff (rst)
        !inValid |-> !detOut);
    end
  endgenerate
endmodule

bind twoOfFourDetect twoOfFourChk #(.WIN(WIN), .REG_OUT(REG_OUT)) uChk (
  .clk    (clk),
  .rst    (rst),
  .inValid(inValid),
  .inBit  (inBit),
  .detOut (detOut),
  .histQ  (histQ),
  .hit    (hitNow)
);

// File: tb/tb_twoOfFourDetect.sv
`timescale 1ns/1ps
module tb_twoOfFourDetect;
  logic clk = 1'b0;
  logic rst;
  logic inValid;
  logic inBit;
  logic combOut;
  logic regOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [2:0] mHist;

  always #10 clk = ~clk;  // 50 MHz

  twoOfFourDetect #(.WIN(4), .REG_OUT(1'b0)) dut (
    .clk(clk), .rst(rst), .inValid(inValid), .inBit(inBit), .detOut(combOut));

  twoOfFourDetect #(.WIN(4), .REG_OUT(1'b1)) dutReg (
    .clk(clk), .rst(rst), .inValid(inValid), .inBit(inBit), .detOut(regOut));

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  // one cycle: drive, check combinational flag, clock, check registered flag
  task automatic step(input logic v, input logic b, input string tag);
    logic exp;
    string t;
    @(negedge clk);
    inValid = v;
    inBit   = b;
    #2;
    exp = v && ($countones({mHist, b}) == 2);
    if (tag != "") t = tag;
    else if (!v)   t = "R6";
    else if (b)    t = "R4/R2";
    else           t = "R3/R2";
    chk(t, combOut, exp);
    @(posedge clk);
    #2;
    chk("R7", regOut, exp);
    if (v) mHist = {mHist[1:0], b};
  endtask

  task automatic loadHist(input logic [2:0] s);
    step(1'b1, s[2], "R5");
    step(1'b1, s[1], "R5");
    step(1'b1, s[0], "R5");
  endtask

  task automatic worked(input logic [2:0] s, input logic b, input logic lit);
    loadHist(s);
    @(negedge clk);
    inValid = 1'b1;
    inBit   = b;
    #2;
    chk("R8", combOut, lit);
    @(posedge clk);
    #2;
    chk("R8", regOut, lit);
    mHist = {mHist[1:0], b};
  endtask

  initial begin
    rst = 1'b1; inValid = 1'b0; inBit = 1'b0; mHist = '0;
    repeat (3) @(posedge clk);
    #2;
    chk("R1", regOut, 1'b0);
    chk("R1", combOut, 1'b0);
    @(negedge clk);
    rst = 1'b0;
    // R1: bits before reset count as 0
    step(1'b1, 1'b1, "R1");
    step(1'b1, 1'b1, "R1");

    // every history and input combination (R2, R3, R4, R5)
    for (int s = 0; s < 8; s++) begin
      for (int b = 0; b < 2; b++) begin
        loadHist(3'(s));
        step(1'b1, 1'(b), "");
      end
    end

    // R8 fixed cases
    worked(3'b000, 1'b1, 1'b0);
    worked(3'b001, 1'b1, 1'b1);
    worked(3'b110, 1'b0, 1'b1);
    worked(3'b111, 1'b0, 1'b0);
    worked(3'b111, 1'b1, 1'b0);

    // R6: invalid cycles hold history and give 0
    loadHist(3'b011);
    step(1'b0, 1'b1, "R6");
    step(1'b0, 1'b0, "R6");
    step(1'b1, 1'b0, "R6");
    loadHist(3'b001);
    step(1'b0, 1'b1, "R6");
    step(1'b1, 1'b1, "R6");

    // R5: shift order 101 + 1 -> 011, then 0 gives two ones
    loadHist(3'b101);
    step(1'b1, 1'b1, "R5");
    step(1'b1, 1'b0, "R5");

    // random stream with gaps
    for (int i = 0; i < 600; i++) begin
      step(($urandom % 4) != 0, 1'($urandom), "");
    end

    // R1: reset mid-stream clears history
    loadHist(3'b110);
    @(negedge clk);
    rst = 1'b1; inValid = 1'b0;
    @(posedge clk);
    #2;
    chk("R1", regOut, 1'b0);
    @(negedge clk);
    rst = 1'b0;
    mHist = '0;
    step(1'b1, 1'b0, "R1");
    step(1'b1, 1'b1, "R1");
    step(1'b1, 1'b1, "R1");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule